// File: doc/BRIEF.md
# Sorted Cell Boundary Extractor

This block consumes a stream of cell keys that arrive already sorted in non-decreasing order, one element per accepted cycle, each carrying its position index in the stream. For every key present in the stream, it records two values in tables addressed by the key. The first value is the index at which that key's run begins. The second is the exclusive end of the run: the index one past the run's last element. Keys that never occur keep an all-ones sentinel that marks an empty cell.

Run edges are found by comparing each accepted key with the one accepted just before it. Because the input is sorted, every entry in both tables is written exactly once per pass. A flag on the final element closes the last run and ends the pass. A clear operation walks both tables, one address per cycle, and restores the sentinel before a new pass. A combinational readback port returns both entries for any chosen key. A sticky flag reports any key that is smaller than its predecessor.

Top module: `cell_bound_extract`

## Requirements
- R1: After reset every start and end entry reads the sentinel, which is all ones across ENT_W = IDX_W+1 bits (127 with defaults). After reset in_ready is high, and done and order_err are low.
- R2: The first element accepted in a pass writes its index into the start entry of its key.
- R3: An accepted element whose key differs from the previously accepted key of the same pass writes its index into the start entry of its own key. In the same cycle it writes the same index into the end entry of the previous key.
- R4: An accepted element whose key equals the previous key writes no entry, so a run's start entry keeps the run's first index.
- R5: An accepted element with in_last high writes its index plus one into the end entry of its key and closes the pass. The next accepted element then begins a new pass under R2.
- R6: done is high for exactly the one cycle after the element with in_last is accepted, and the tables already hold that pass's results in that cycle.
- R7: Keys absent from a pass keep the sentinel in both tables, provided the pass started from cleared tables.
- R8: A cycle with clr_req high accepts nothing. From the next cycle, clr_busy stays high for exactly 2**KEY_W cycles and in_ready is low throughout. Afterwards every entry reads the sentinel and no pass is open.
- R9: An accepted key that is smaller than the previous key of the same pass sets order_err from the next cycle. order_err stays set until a clr_req.
- R10: rd_start and rd_end show the entries for rd_key in the same cycle, with no register on the read path.
- R11: When the last element also begins a new run, both end writes (R3 and R5) take effect in the same cycle.
- R12: No element is taken while in_valid is low. Idle cycles inside a pass change neither the tables nor the previous key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_req | input | 1 | Starts a clear walk of both tables |
| in_valid | input | 1 | Stream element present |
| in_ready | output | 1 | Block can take an element this cycle |
| in_key | input | KEY_W | Cell key of the element |
| in_idx | input | IDX_W | Position index of the element |
| in_last | input | 1 | Element is the final one of the pass |
| rd_key | input | KEY_W | Key to read back |
| rd_start | output | IDX_W+1 | Start entry for rd_key |
| rd_end | output | IDX_W+1 | Exclusive end entry for rd_key |
| clr_busy | output | 1 | Clear walk in progress |
| done | output | 1 | One-cycle pulse after the final element |
| order_err | output | 1 | Sticky descending-key flag |

## Verification
Two events can land in the same cycle. One is the boundary that closes the previous run's end entry; the other is the final-element write of the new key's end entry. Both target the end table at once. The bench provokes this by ending streams on a key that differs from its predecessor, including the short stream 1,1,6,6,6,9 and a sweep of eight sorted streams whose run lengths follow from integer division. It then reads every key back and compares both entries against tables built from the stream alone. A second collision, a clear request arriving while an element is offered, is judged by checking that in_ready drops in that cycle and that the tables read all sentinel afterwards.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
   // widest key the library accepts; table size grows as 2**KEY_W
   localparam int unsigned CBE_MAX_KEY_W = 8;
   localparam int unsigned CBE_MAX_IDX_W = 16;

   typedef enum logic [0:0] {
      WR_SINGLE = 1'b0,
      WR_DUAL   = 1'b1
   } cbe_wr_kind_e;
endpackage

// File: rtl/cbe_clear_seq.sv
module cbe_clear_seq #(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_req,
   output logic          busy,
   output logic          clr_we,
   output logic [AW-1:0] clr_addr
);
   localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

   logic [AW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (clr_req) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == LAST_ADDR) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign clr_we   = busy_q;
   assign clr_addr = cnt_q;
endmodule

// File: rtl/cbe_run_track.sv
module cbe_run_track #(
   parameter int unsigned KEY_W = 4,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned ENT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             accept,
   input  logic [KEY_W-1:0] key,
   input  logic [IDX_W-1:0] idx,
   input  logic             last,
   output logic             s_we,
   output logic [KEY_W-1:0] s_addr,
   output logic [ENT_W-1:0] s_data,
   output logic             eb_we,
   output logic [KEY_W-1:0] eb_addr,
   output logic [ENT_W-1:0] eb_data,
   output logic             el_we,
   output logic [KEY_W-1:0] el_addr,
   output logic [ENT_W-1:0] el_data,
   output logic             pass_open,
   output logic [KEY_W-1:0] prev_key,
   output logic             order_err,
   output logic             done
);
   logic             open_q;
   logic [KEY_W-1:0] prev_q;
   logic             err_q;
   logic             done_q;
   logic             key_change;
   logic             descend;
   logic [ENT_W-1:0] idx_ext;

   assign idx_ext    = ENT_W'(idx);
   assign key_change = open_q && (key != prev_q);
   assign descend    = accept && open_q && (key < prev_q);

   // start of a run: first element of the pass or a changed key
   assign s_we    = accept && (!open_q || key_change);
   assign s_addr  = key;
   assign s_data  = idx_ext;

   // boundary close of the run that just ended
   assign eb_we   = accept && key_change;
   assign eb_addr = prev_q;
   assign eb_data = idx_ext;

   // final element closes its own run
   assign el_we   = accept && last;
   assign el_addr = key;
   assign el_data = idx_ext + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         prev_q <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (flush) begin
         open_q <= 1'b0;
         prev_q <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= accept && last;
         if (accept) begin
            prev_q <= key;
            open_q <= !last;
         end
         if (descend) err_q <= 1'b1;
      end
   end

   assign pass_open = open_q;
   assign prev_key  = prev_q;
   assign order_err = err_q;
   assign done      = done_q;
endmodule

// File: rtl/cbe_table.sv
module cbe_table #(
   parameter int unsigned AW   = 4,
   parameter int unsigned DW   = 7,
   parameter int unsigned N_WR = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_we,
   input  logic [AW-1:0]             clr_addr,
   input  logic [N_WR-1:0]           we,
   input  logic [N_WR-1:0][AW-1:0]   waddr,
   input  logic [N_WR-1:0][DW-1:0]   wdata,
   input  logic [AW-1:0]             raddr,
   output logic [DW-1:0]             rdata
);
   localparam int unsigned N_ENT = 1 << AW;

   logic [N_ENT*DW-1:0] flat;

   generate
      for (genvar e = 0; e < N_ENT; e++) begin : g_ent
         logic [DW-1:0] q;
         logic          hit;
         logic [DW-1:0] nxt;

         always_comb begin
            hit = 1'b0;
            nxt = q;
            for (int p = 0; p < N_WR; p++) begin
               if (we[p] && (waddr[p] == AW'(e))) begin
                  hit = 1'b1;
                  nxt = wdata[p];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 q <= '1;
            else if (clr_we && (clr_addr == AW'(e)))    q <= '1;
            else if (hit)                               q <= nxt;
         end

         assign flat[e*DW +: DW] = q;
      end
   endgenerate

   assign rdata = flat[raddr*DW +: DW];
endmodule

// File: rtl/cell_bound_extract.sv
module cell_bound_extract #(
   parameter int unsigned KEY_W = 4,
   parameter int unsigned IDX_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_req,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [KEY_W-1:0]   in_key,
   input  logic [IDX_W-1:0]   in_idx,
   input  logic               in_last,
   input  logic [KEY_W-1:0]   rd_key,
   output logic [IDX_W:0]     rd_start,
   output logic [IDX_W:0]     rd_end,
   output logic               clr_busy,
   output logic               done,
   output logic               order_err
);
   import cbe_pkg::*;

   localparam int unsigned ENT_W = IDX_W + 1;
   localparam cbe_wr_kind_e START_KIND = WR_SINGLE;
   localparam cbe_wr_kind_e END_KIND   = WR_DUAL;
   localparam int unsigned START_PORTS = (START_KIND == WR_DUAL) ? 2 : 1;
   localparam int unsigned END_PORTS   = (END_KIND == WR_DUAL) ? 2 : 1;

   generate
      if (KEY_W < 1 || KEY_W > CBE_MAX_KEY_W) begin : g_bad_key
         $error("KEY_W out of supported range");
      end
      if (IDX_W < 1 || IDX_W > CBE_MAX_IDX_W) begin : g_bad_idx
         $error("IDX_W out of supported range");
      end
   endgenerate

   logic             accept;
   logic             clr_we;
   logic [KEY_W-1:0] clr_addr;
   logic             s_we, eb_we, el_we;
   logic [KEY_W-1:0] s_addr, eb_addr, el_addr;
   logic [ENT_W-1:0] s_data, eb_data, el_data;
   logic             pass_open;
   logic [KEY_W-1:0] prev_key;

   assign in_ready = !clr_busy && !clr_req;
   assign accept   = in_valid && in_ready;

   cbe_clear_seq #(.AW(KEY_W)) u_clr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_req  (clr_req),
      .busy     (clr_busy),
      .clr_we   (clr_we),
      .clr_addr (clr_addr)
   );

   cbe_run_track #(.KEY_W(KEY_W), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (clr_req),
      .accept    (accept),
      .key       (in_key),
      .idx       (in_idx),
      .last      (in_last),
      .s_we      (s_we),
      .s_addr    (s_addr),
      .s_data    (s_data),
      .eb_we     (eb_we),
      .eb_addr   (eb_addr),
      .eb_data   (eb_data),
      .el_we     (el_we),
      .el_addr   (el_addr),
      .el_data   (el_data),
      .pass_open (pass_open),
      .prev_key  (prev_key),
      .order_err (order_err),
      .done      (done)
   );

   logic [START_PORTS-1:0]            st_we;
   logic [START_PORTS-1:0][KEY_W-1:0] st_addr;
   logic [START_PORTS-1:0][ENT_W-1:0] st_data;
   logic [END_PORTS-1:0]              en_we;
   logic [END_PORTS-1:0][KEY_W-1:0]   en_addr;
   logic [END_PORTS-1:0][ENT_W-1:0]   en_data;

   assign st_we[0]   = s_we;
   assign st_addr[0] = s_addr;
   assign st_data[0] = s_data;

   generate
      if (END_PORTS == 2) begin : g_end_dual
         // the two end writes never share an address: they differ by key
         assign en_we   = {el_we, eb_we};
         assign en_addr = {el_addr, eb_addr};
         assign en_data = {el_data, eb_data};
      end else begin : g_end_single
         assign en_we[0]   = eb_we || el_we;
         assign en_addr[0] = el_we ? el_addr : eb_addr;
         assign en_data[0] = el_we ? el_data : eb_data;
      end
   endgenerate

   cbe_table #(.AW(KEY_W), .DW(ENT_W), .N_WR(START_PORTS)) u_start_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (clr_we),
      .clr_addr (clr_addr),
      .we       (st_we),
      .waddr    (st_addr),
      .wdata    (st_data),
      .raddr    (rd_key),
      .rdata    (rd_start)
   );

   cbe_table #(.AW(KEY_W), .DW(ENT_W), .N_WR(END_PORTS)) u_end_tab (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (clr_we),
      .clr_addr (clr_addr),
      .we       (en_we),
      .waddr    (en_addr),
      .wdata    (en_data),
      .raddr    (rd_key),
      .rdata    (rd_end)
   );
endmodule

// File: rtl/cbe_checker.sv
module cbe_checker #(
   parameter int unsigned KEY_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_req,
   input logic             clr_busy,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_last,
   input logic [KEY_W-1:0] in_key,
   input logic             done,
   input logic             order_err,
   input logic             pass_open,
   input logic [KEY_W-1:0] prev_key
);
   p_ready_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_busy || clr_req) |-> !in_ready);

   p_clear_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (clr_busy && !pass_open && !order_err));

   p_done_follows_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> done);

   p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(in_valid && in_ready && in_last));

   p_pass_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !pass_open);

   p_err_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && pass_open && (in_key < prev_key)) |=> order_err);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (order_err && !clr_req) |=> order_err);

   p_idle_keeps_prev_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !clr_req) |=> $stable(prev_key));
endmodule

bind cell_bound_extract cbe_checker #(.KEY_W(KEY_W)) u_chk (.*);

// File: tb/cell_bound_extract_tb.sv
module cell_bound_extract_tb;
   localparam int KEY_W = 4;
   localparam int IDX_W = 6;
   localparam int NC    = 1 << KEY_W;
   localparam int SENT  = (1 << (IDX_W + 1)) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr_req = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [KEY_W-1:0] in_key = '0;
   logic [IDX_W-1:0] in_idx = '0;
   logic             in_last = 1'b0;
   logic [KEY_W-1:0] rd_key = '0;
   logic [IDX_W:0]   rd_start, rd_end;
   logic             clr_busy, done, order_err;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 1'b0;
   int kq [64];
   int exp_s [NC];
   int exp_e [NC];

   always #5 clk = ~clk;

   cell_bound_extract #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .in_valid(in_valid),
      .in_ready(in_ready), .in_key(in_key), .in_idx(in_idx), .in_last(in_last),
      .rd_key(rd_key), .rd_start(rd_start), .rd_end(rd_end),
      .clr_busy(clr_busy), .done(done), .order_err(order_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic reset_expect();
      for (int c = 0; c < NC; c++) begin
         exp_s[c] = SENT;
         exp_e[c] = SENT;
      end
   endtask

   // R10: read path is combinational, compare a moment after changing rd_key
   task automatic check_tables(input string req);
      for (int c = 0; c < NC; c++) begin
         rd_key = KEY_W'(c);
         #1;
         chk({req, " start"}, int'(rd_start), exp_s[c]);
         chk({req, " end"},   int'(rd_end),   exp_e[c]);
      end
   endtask

   task automatic do_clear();
      int cnt;
      @(negedge clk);
      clr_req = 1'b1;
      #1 chk("R8 ready low on request", int'(in_ready), 0);
      @(negedge clk);
      clr_req = 1'b0;
      chk("R8 ready low while busy", int'(in_ready), 0);
      cnt = 0;
      while (clr_busy) begin
         cnt++;
         @(negedge clk);
      end
      chk("R8 busy length", cnt, NC);
      chk("R8 ready after clear", int'(in_ready), 1);
      reset_expect();
   endtask

   // R2 R3 R4 R5 R11: expectation from the stream alone, end exclusive
   task automatic build_expect(input int n);
      for (int i = 0; i < n; i++) begin
         if (i == 0 || kq[i] != kq[i-1]) exp_s[kq[i]] = i;
         if (i == n - 1 || kq[i+1] != kq[i]) exp_e[kq[i]] = i + 1;
      end
   endtask

   task automatic play(input int n, input bit gaps, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_key   = KEY_W'(kq[i]);
         in_idx   = IDX_W'(i);
         in_last  = (i == n - 1);
         @(posedge clk);
         if (gaps && (i % 3 == 1) && (i != n - 1)) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_key   = KEY_W'(NC - 1 - kq[i]);   // R12 junk while idle
            in_idx   = '1;
            in_last  = 1'b1;
            @(posedge clk);
         end
      end
      @(negedge clk);
      chk({req, " R6 done pulse"}, int'(done), 1);
      in_valid = 1'b0;
      in_last  = 1'b0;
      build_expect(n);
      check_tables(req);
      @(negedge clk);
      chk({req, " R6 done single cycle"}, int'(done), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      reset_expect();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready", int'(in_ready), 1);
      chk("R1 done", int'(done), 0);
      chk("R1 order_err", int'(order_err), 0);
      check_tables("R1 reset sentinel");

      // R3 R4 R11: cell 6 occupies indices 2..4, start 2 end 5
      kq[0] = 1; kq[1] = 1; kq[2] = 6; kq[3] = 6; kq[4] = 6; kq[5] = 9;
      play(6, 1'b0, "R3 short stream");
      @(negedge clk);
      rd_key = 4'd6;
      #1;
      chk("R3 cell6 start", int'(rd_start), 2);
      chk("R3 cell6 end",   int'(rd_end),   5);
      rd_key = 4'd1;
      #1;
      chk("R4 cell1 start", int'(rd_start), 0);

      do_clear();
      check_tables("R8 after clear");

      // R12: same stream with idle gaps yields same tables
      play(6, 1'b1, "R12 gapped stream");

      // R8: request collides with an offered element
      @(negedge clk);
      in_valid = 1'b1;
      in_key   = 4'd3;
      in_idx   = '0;
      in_last  = 1'b1;
      clr_req  = 1'b1;
      #1 chk("R8 collide ready", int'(in_ready), 0);
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      clr_req  = 1'b0;
      chk("R8 collide no done", int'(done), 0);
      while (clr_busy) @(negedge clk);
      reset_expect();
      check_tables("R8 collide sentinel");

      // R2 R5 R7: single element pass
      kq[0] = NC - 1;
      play(1, 1'b0, "R5 single element");

      // sweep of sorted streams
      for (int p = 0; p < 8; p++) begin
         int n, used, base;
         do_clear();
         n    = 20 + 3 * p;
         used = 1 + 2 * (p % 7);
         base = (p % 2 == 1) ? (NC - used) : 0;
         for (int i = 0; i < n; i++) kq[i] = base + (i * used) / n;
         play(n, p[0], "R7 sweep");
         chk("R9 sweep no error", int'(order_err), 0);
      end

      // R5: a new pass without clear overwrites touched keys only
      kq[0] = 2; kq[1] = 2; kq[2] = 3;
      play(3, 1'b0, "R5 second pass");

      // R9: descending key
      do_clear();
      @(negedge clk);
      in_valid = 1'b1; in_key = 4'd5; in_idx = 6'd0; in_last = 1'b0;
      @(negedge clk);
      in_key = 4'd3; in_idx = 6'd1;
      @(negedge clk);
      chk("R9 error raised", int'(order_err), 1);
      in_key = 4'd3; in_idx = 6'd2; in_last = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 error sticky", int'(order_err), 1);
      do_clear();
      chk("R9 error cleared", int'(order_err), 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule